// File: doc/BRIEF.md
# Console I/O Port Decoder

This block turns an 8-bit Z80 I/O port address and the CPU bus strobes into the chip selects of a retro game console. It produces active-low selects for the controllers, the video processor, the primary sound chip and two expansion-mode registers. It also produces the two-wire bus-control code for a PSG-style secondary sound chip, plus an enable for the level-shifting data transceiver in front of the video processor.

The older console ports are decoded only on the top three address bits, so each of them answers a block of 32 addresses. The extension ports sit in groups that the older ports leave unused, and they are decoded on all eight bits. Every output is registered: a bus state presented before a rising clock edge shows at the outputs just after that edge.

Top module: `console_port_decoder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after any edge taken in reset, every active-low output is high and `psg_bdir` and `psg_bc1` are 0.
- R2: A write (wr_n=0, rd_n=1) to any address with bits [7:5] = 3'b100 drives `kpad_mode_n` low.
- R3: A write to any address with bits [7:5] = 3'b110 drives `joy_mode_n` low.
- R4: A read of any address with bits [7:5] = 3'b101 drives `vid_rd_n` low, and a write drives `vid_wr_n` low. `xcvr_en_n` is low exactly when one of those two is low. The transceiver direction is taken from `vid_wr_n`.
- R5: For bits [7:5] = 3'b111, a read drives `pad_rd_n` low and a write drives `snd_wr_n` low.
- R6: A write to exactly 8'h53 drives `xmem_wr_n` low, and a write to exactly 8'h7F drives `romoff_wr_n` low. Every other address leaves them high, including reads of those two ports.
- R7: PSG code as {psg_bdir, psg_bc1}: a write to 8'h50 gives 2'b11 (address latch), a write to 8'h51 gives 2'b10 (data write), a read of 8'h52 gives 2'b01 (data read). Every other access gives 2'b00.
- R8: Nothing is decoded unless `iorq_n` is 0 and `m1_n` is 1. An interrupt-acknowledge cycle (both low) leaves every output inactive.
- R9: A cycle counts as a read only when rd_n=0 and wr_n=1, and as a write only when wr_n=0 and rd_n=1. If both strobes are low, nothing is decoded. At most one active-low select other than `xcvr_en_n` is low at a time.
- R10: Each output change appears one clock edge after the bus state that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | I/O port address A7..A0 |
| iorq_n | input | 1 | I/O request, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| kpad_mode_n | output | 1 | Controller keypad scan mode select |
| joy_mode_n | output | 1 | Controller joystick scan mode select |
| vid_rd_n | output | 1 | Video processor read select |
| vid_wr_n | output | 1 | Video processor write select, also transceiver direction |
| xcvr_en_n | output | 1 | Video data transceiver enable |
| pad_rd_n | output | 1 | Controller read select |
| snd_wr_n | output | 1 | Primary sound chip write select |
| xmem_wr_n | output | 1 | Extended-memory register write select |
| romoff_wr_n | output | 1 | ROM-disable register write select |
| psg_bdir | output | 1 | PSG bus direction |
| psg_bc1 | output | 1 | PSG bus control 1 |

## Verification
The transceiver enable must fire in the same cycle as a video select. A legacy select must never fire in the same cycle as an extension select or a PSG code. The bench provokes both overlaps by sweeping every address against every strobe pair, including the illegal both-low pair, and under both disqualifying qualifier states. A behavioural model predicts each output separately, and every output is compared after every edge. So an extra select that fires next to a correct one is caught, even when the correct select is present.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

    typedef struct packed {
        logic kpad_mode_n;
        logic joy_mode_n;
        logic vid_rd_n;
        logic vid_wr_n;
        logic xcvr_en_n;
        logic pad_rd_n;
        logic snd_wr_n;
        logic xmem_wr_n;
        logic romoff_wr_n;
        logic psg_bdir;
        logic psg_bc1;
    } port_sel_t;

    localparam port_sel_t SEL_IDLE = '{
        kpad_mode_n: 1'b1, joy_mode_n: 1'b1, vid_rd_n: 1'b1, vid_wr_n: 1'b1,
        xcvr_en_n: 1'b1, pad_rd_n: 1'b1, snd_wr_n: 1'b1, xmem_wr_n: 1'b1,
        romoff_wr_n: 1'b1, psg_bdir: 1'b0, psg_bc1: 1'b0
    };

endpackage

// File: rtl/cpd_match.sv
// Compares a key against N constant codes and gives one hit bit per code.
module cpd_match #(
    parameter int               KEY_W = 3,
    parameter int               N     = 4,
    parameter logic [N*KEY_W-1:0] CODES = '0
) (
    input  logic [KEY_W-1:0] key,
    output logic [N-1:0]     hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = (key == CODES[i*KEY_W +: KEY_W]);
    end
endmodule

// File: rtl/cpd_psg_code.sv
// Two-wire PSG bus-control code from the three PSG port hits and strobes.
module cpd_psg_code (
    input  logic hit_latch,
    input  logic hit_data_wr,
    input  logic hit_data_rd,
    input  logic rd_go,
    input  logic wr_go,
    output logic bdir,
    output logic bc1
);
    always_comb begin
        bdir = wr_go && (hit_latch || hit_data_wr);
        bc1  = (wr_go && hit_latch) || (rd_go && hit_data_rd);
    end
endmodule

// File: rtl/console_port_decoder.sv
module console_port_decoder #(
    parameter int         ADDR_W      = 8,
    parameter int         GRP_W       = 3,
    parameter logic [2:0] G_KPAD      = 3'b100,
    parameter logic [2:0] G_VIDEO     = 3'b101,
    parameter logic [2:0] G_JOY       = 3'b110,
    parameter logic [2:0] G_PAD_SND   = 3'b111,
    parameter logic [7:0] P_PSG_LATCH = 8'h50,
    parameter logic [7:0] P_PSG_WR    = 8'h51,
    parameter logic [7:0] P_PSG_RD    = 8'h52,
    parameter logic [7:0] P_XMEM      = 8'h53,
    parameter logic [7:0] P_ROMOFF    = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              iorq_n,
    input  logic              m1_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              kpad_mode_n,
    output logic              joy_mode_n,
    output logic              vid_rd_n,
    output logic              vid_wr_n,
    output logic              xcvr_en_n,
    output logic              pad_rd_n,
    output logic              snd_wr_n,
    output logic              xmem_wr_n,
    output logic              romoff_wr_n,
    output logic              psg_bdir,
    output logic              psg_bc1
);
    import cpd_pkg::*;

    localparam int N_GRP = 4;
    localparam int N_EXT = 5;
    localparam logic [N_GRP*GRP_W-1:0]  GRP_CODES =
        {G_PAD_SND[GRP_W-1:0], G_JOY[GRP_W-1:0], G_VIDEO[GRP_W-1:0], G_KPAD[GRP_W-1:0]};
    localparam logic [N_EXT*ADDR_W-1:0] EXT_CODES =
        {P_ROMOFF[ADDR_W-1:0], P_XMEM[ADDR_W-1:0], P_PSG_RD[ADDR_W-1:0],
         P_PSG_WR[ADDR_W-1:0], P_PSG_LATCH[ADDR_W-1:0]};

    logic [N_GRP-1:0] grp_hit;
    logic [N_EXT-1:0] ext_hit;
    logic             io_ok, rd_go, wr_go;
    logic             bdir_c, bc1_c;
    port_sel_t        sel_d, sel_q;

    // Legacy ports: partial decode on the top address bits only.
    cpd_match #(.KEY_W(GRP_W), .N(N_GRP), .CODES(GRP_CODES)) u_grp (
        .key (addr[ADDR_W-1 -: GRP_W]),
        .hit (grp_hit)
    );

    // Extension ports: full decode on every address bit.
    cpd_match #(.KEY_W(ADDR_W), .N(N_EXT), .CODES(EXT_CODES)) u_ext (
        .key (addr),
        .hit (ext_hit)
    );

    always_comb begin
        io_ok = !iorq_n && m1_n;
        rd_go = io_ok && !rd_n && wr_n;
        wr_go = io_ok && !wr_n && rd_n;
    end

    cpd_psg_code u_psg (
        .hit_latch   (ext_hit[0]),
        .hit_data_wr (ext_hit[1]),
        .hit_data_rd (ext_hit[2]),
        .rd_go       (rd_go),
        .wr_go       (wr_go),
        .bdir        (bdir_c),
        .bc1         (bc1_c)
    );

    always_comb begin
        sel_d             = SEL_IDLE;
        sel_d.kpad_mode_n = !(wr_go && grp_hit[0]);
        sel_d.vid_rd_n    = !(rd_go && grp_hit[1]);
        sel_d.vid_wr_n    = !(wr_go && grp_hit[1]);
        sel_d.xcvr_en_n   = !((rd_go || wr_go) && grp_hit[1]);
        sel_d.joy_mode_n  = !(wr_go && grp_hit[2]);
        sel_d.pad_rd_n    = !(rd_go && grp_hit[3]);
        sel_d.snd_wr_n    = !(wr_go && grp_hit[3]);
        sel_d.xmem_wr_n   = !(wr_go && ext_hit[3]);
        sel_d.romoff_wr_n = !(wr_go && ext_hit[4]);
        sel_d.psg_bdir    = bdir_c;
        sel_d.psg_bc1     = bc1_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_IDLE;
        else        sel_q <= sel_d;
    end

    assign kpad_mode_n = sel_q.kpad_mode_n;
    assign joy_mode_n  = sel_q.joy_mode_n;
    assign vid_rd_n    = sel_q.vid_rd_n;
    assign vid_wr_n    = sel_q.vid_wr_n;
    assign xcvr_en_n   = sel_q.xcvr_en_n;
    assign pad_rd_n    = sel_q.pad_rd_n;
    assign snd_wr_n    = sel_q.snd_wr_n;
    assign xmem_wr_n   = sel_q.xmem_wr_n;
    assign romoff_wr_n = sel_q.romoff_wr_n;
    assign psg_bdir    = sel_q.psg_bdir;
    assign psg_bc1     = sel_q.psg_bc1;
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] addr,
    input logic       iorq_n,
    input logic       m1_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       kpad_mode_n,
    input logic       joy_mode_n,
    input logic       vid_rd_n,
    input logic       vid_wr_n,
    input logic       xcvr_en_n,
    input logic       pad_rd_n,
    input logic       snd_wr_n,
    input logic       xmem_wr_n,
    input logic       romoff_wr_n,
    input logic       psg_bdir,
    input logic       psg_bc1
);
    logic [8:0] sel_act;
    logic       all_idle, io_wr, io_rd;
    assign sel_act  = ~{kpad_mode_n, joy_mode_n, vid_rd_n, vid_wr_n, pad_rd_n,
                        snd_wr_n, xmem_wr_n, romoff_wr_n, 1'b1};
    assign all_idle = (sel_act == '0) && xcvr_en_n && !psg_bdir && !psg_bc1;
    assign io_wr    = !iorq_n && m1_n && !wr_n && rd_n;
    assign io_rd    = !iorq_n && m1_n && !rd_n && wr_n;

    // R1
    a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> all_idle);

    // R8
    a_r8_unqualified_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (iorq_n || !m1_n) |=> all_idle);

    // R9
    a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_act));

    // R9
    a_r9_both_strobes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |=> all_idle);

    // R4
    a_r4_video_write_xcvr: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[7:5] == 3'b101) |=> (!vid_wr_n && !xcvr_en_n));

    // R6
    a_r6_xmem_write: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr == 8'h53) |=> !xmem_wr_n);

    // R7
    a_r7_psg_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr == 8'h50) |=> (psg_bdir && psg_bc1));

    // R7
    a_r7_psg_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && addr == 8'h52) |=> (!psg_bdir && psg_bc1));

    // R7
    a_r7_psg_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (psg_bdir || psg_bc1) |-> (sel_act == '0 && xcvr_en_n));
endmodule

bind console_port_decoder cpd_checker u_cpd_checker (
    .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .kpad_mode_n(kpad_mode_n), .joy_mode_n(joy_mode_n),
    .vid_rd_n(vid_rd_n), .vid_wr_n(vid_wr_n), .xcvr_en_n(xcvr_en_n),
    .pad_rd_n(pad_rd_n), .snd_wr_n(snd_wr_n), .xmem_wr_n(xmem_wr_n),
    .romoff_wr_n(romoff_wr_n), .psg_bdir(psg_bdir), .psg_bc1(psg_bc1)
);

// File: tb/tb_console_port_decoder.sv
`timescale 1ns/1ps
module tb_console_port_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic kpad_mode_n, joy_mode_n, vid_rd_n, vid_wr_n, xcvr_en_n, pad_rd_n;
    logic snd_wr_n, xmem_wr_n, romoff_wr_n, psg_bdir, psg_bc1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    console_port_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
        .rd_n(rd_n), .wr_n(wr_n), .kpad_mode_n(kpad_mode_n), .joy_mode_n(joy_mode_n),
        .vid_rd_n(vid_rd_n), .vid_wr_n(vid_wr_n), .xcvr_en_n(xcvr_en_n),
        .pad_rd_n(pad_rd_n), .snd_wr_n(snd_wr_n), .xmem_wr_n(xmem_wr_n),
        .romoff_wr_n(romoff_wr_n), .psg_bdir(psg_bdir), .psg_bc1(psg_bc1)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at t=%0t addr=%02h: actual %b expected %b",
                     tag, $time, addr, act, exp);
        end
    endtask

    // Behavioural expectation from the requirements, using plain integers.
    task automatic expect_all(input int a, input bit iorq, input bit m1,
                              input bit rd, input bit wr, input bit in_reset);
        bit ok, r, w;
        int grp;
        ok  = !in_reset && !iorq && m1;
        r   = ok && !rd && wr;     // R9 read only with one strobe
        w   = ok && !wr && rd;     // R9 write only with one strobe
        grp = a / 32;
        chk("R2 kpad_mode_n", kpad_mode_n, !(w && grp == 4));
        chk("R3 joy_mode_n",  joy_mode_n,  !(w && grp == 6));
        chk("R4 vid_rd_n",    vid_rd_n,    !(r && grp == 5));
        chk("R4 vid_wr_n",    vid_wr_n,    !(w && grp == 5));
        chk("R4 xcvr_en_n",   xcvr_en_n,   !((r || w) && grp == 5));
        chk("R5 pad_rd_n",    pad_rd_n,    !(r && grp == 7));
        chk("R5 snd_wr_n",    snd_wr_n,    !(w && grp == 7));
        chk("R6 xmem_wr_n",   xmem_wr_n,   !(w && a == 'h53));
        chk("R6 romoff_wr_n", romoff_wr_n, !(w && a == 'h7F));
        chk("R7 psg_bdir",    psg_bdir,    w && (a == 'h50 || a == 'h51));
        chk("R7 psg_bc1",     psg_bc1,     (w && a == 'h50) || (r && a == 'h52));
    endtask

    // Drive after a falling edge; R10: result is visible after the next rising edge,
    // so it is compared at the following falling edge.
    task automatic apply(input int a, input bit iorq, input bit m1,
                         input bit rd, input bit wr);
        addr = a[7:0]; iorq_n = iorq; m1_n = m1; rd_n = rd; wr_n = wr;
        @(negedge clk);
        expect_all(a, iorq, m1, rd, wr, 1'b0);
    endtask

    initial begin
        // R1: outputs idle while reset is held, even with a live write on the bus.
        addr = 8'h50; iorq_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_all(8'h50, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        iorq_n = 1'b1; wr_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        expect_all(8'h50, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);

        // R10: a single-cycle access shows one edge later, then clears.
        apply(8'h53, 1'b0, 1'b1, 1'b1, 1'b0);
        apply(8'h53, 1'b1, 1'b1, 1'b1, 1'b1);

        // Full sweep: every address, every strobe pair, qualified and not (R2..R9).
        for (int q = 0; q < 3; q++) begin
            for (int a = 0; a < 256; a++) begin
                for (int s = 0; s < 4; s++) begin
                    apply(a, (q == 1), (q != 2), s[0], s[1]);
                end
            end
        end

        // R1: reset asserted mid-access clears the outputs.
        apply(8'hA3, 1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        expect_all(8'hA3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        rst_n = 1'b1;
        apply(8'hE7, 1'b0, 1'b1, 1'b0, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule